// File: doc/BRIEF.md
# Queued SPI Master with Command/Transmit/Receive Queue

This block is an SPI bus master that works through a queue of up to sixteen transfers with no host involvement between entries. Each queue slot carries three words: a command word (which chip-select lines to drive, whether to use the programmed bit count, whether to keep the selection held into the next slot), a transmit word and a receive word. The host reaches the three regions through an address register and a data register. It fills the command and transmit regions, programs the last slot to run, and sets the run bit. It then polls the completion flag and reads the receive region back.

Serial timing comes from a programmable half-period divider. The clock polarity and phase are selectable. Words go out most significant bit first. The sequencer has six named states:
- `SQ_IDLE` waits for the run bit and goes to `SQ_LOAD`.
- `SQ_LOAD` drives the slot's chip selects, starts the shift engine and goes to `SQ_SHIFT`.
- `SQ_SHIFT` waits for the engine's done pulse and goes to `SQ_STORE`.
- `SQ_STORE` writes the received word into the slot. It then goes to one of three states:
  - `SQ_FINISH` after the last slot.
  - `SQ_LOAD` when the slot asked to hold its selection.
  - `SQ_GAP` otherwise.
- `SQ_GAP` keeps the chip selects released for one half period, then goes to `SQ_LOAD`.
- `SQ_FINISH` clears the run bit, sets the completion flag and goes to `SQ_IDLE`.

Top module: `queued_spi_master`

## Requirements
- R1: Host registers sit at `host_addr` offsets 0 mode, 1 control, 2 wrap, 3 status, 4 address and 5 data. The address register holds a region in bits [5:4] and a slot index in bits [3:0]. The regions are transmit = 0, receive = 1 and command = 2. Every data-register access, read or write, advances the index by one, wrapping from 15 to 0 inside the same region.
- R2: Wrap bits [3:0] hold the index of the last slot. Writing 1 to control bit 15 while mode bit 15 (master enable) is set runs slots 0 through that index, in ascending order.
- R3: Control bit 15 reads 1 while the queue runs and clears itself when the last slot completes. Completion also sets status bit 0. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A completion and a clear in the same cycle leave the flag set.
- R4: SCK stays in each level for max(mode[7:0], 2) system clocks, so the values 0 and 1 behave as 2.
- R5: SCK idles at the level of mode bit 9. When mode bit 8 is 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. When it is 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: Words are shifted most significant bit first. A slot shifts the count in mode[13:10] when its command bit 4 is set, where a value of 0 means 16. When command bit 4 is clear the slot shifts 8 bits. The received word is right-aligned with its upper bits zero.
- R7: Wrap bit 4 sets the idle level of all four chip-select outputs. While a slot runs, the lines selected by command bits [3:0] are driven to the opposite level.
- R8: When command bit 5 is set, the chip selects stay driven into the next slot. When it is clear they are released for a gap before the next slot. They are always released after the last slot.
- R9: The word received during a slot is stored in that slot's receive word.
- R10: While master enable is clear, a run request is ignored: control bit 15 stays 0, SCK does not toggle and the completion flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
The sequencer can raise the completion flag in the same clock edge at which the host writes 1 to clear it. The bench first times one queue run, counting cycles from the run request until the flag appears. It then repeats the identical run and places the clearing write exactly on that edge. The outcome is judged at the host port: a read of the status register afterwards must return 1, because the completion wins, and the checker asserts that the flag is set in the cycle after `SQ_FINISH`.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_STORE,
        SQ_GAP,
        SQ_FINISH
    } seq_state_t;

    typedef enum logic {
        SH_IDLE,
        SH_RUN
    } sh_state_t;

    // host register offsets
    localparam logic [2:0] REG_MODE   = 3'd0;
    localparam logic [2:0] REG_CTRL   = 3'd1;
    localparam logic [2:0] REG_WRAP   = 3'd2;
    localparam logic [2:0] REG_STATUS = 3'd3;
    localparam logic [2:0] REG_ADDR   = 3'd4;
    localparam logic [2:0] REG_DATA   = 3'd5;

    // queue regions
    localparam logic [1:0] RGN_TX  = 2'd0;
    localparam logic [1:0] RGN_RX  = 2'd1;
    localparam logic [1:0] RGN_CMD = 2'd2;

    // field positions
    localparam int MODE_CPHA   = 8;
    localparam int MODE_CPOL   = 9;
    localparam int MODE_BITS_L = 10;
    localparam int MODE_MSTR   = 15;
    localparam int CTRL_RUN    = 15;
    localparam int WRAP_CSIV   = 4;
    localparam int CMD_BITSE   = 4;
    localparam int CMD_HOLD    = 5;

endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt_q;

    assign half = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    assign tick = en && (cnt_q == half - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [CNT_W-1:0] nbits,
    input  logic [W-1:0]     tx,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic [W-1:0]     rx,
    output logic             done
);
    localparam int E_W = CNT_W + 1;

    sh_state_t        st_q, st_d;
    logic [W-1:0]     sr_q;
    logic [W-1:0]     rx_q;
    logic [CNT_W-1:0] n_q;
    logic [E_W-1:0]   edge_q;
    logic             tgl_q;
    logic             done_q;
    logic             lead;
    logic             last_edge;
    logic             do_sample;
    logic             do_shift;

    assign lead      = ~edge_q[0];
    assign last_edge = (edge_q == ({n_q, 1'b0} - {{CNT_W{1'b0}}, 1'b1}));
    assign do_sample = cpha ? !lead : lead;
    assign do_shift  = cpha ? (lead && (edge_q != '0)) : !lead;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE: if (start) st_d = SH_RUN;
            SH_RUN:  if (tick && last_edge) st_d = SH_IDLE;
            default: st_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            rx_q   <= '0;
            n_q    <= '0;
            edge_q <= '0;
            tgl_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == SH_IDLE && start) begin
                sr_q   <= tx << (CNT_W'(W) - nbits);
                rx_q   <= '0;
                n_q    <= nbits;
                edge_q <= '0;
                tgl_q  <= 1'b0;
            end else if (st_q == SH_RUN && tick) begin
                tgl_q  <= ~tgl_q;
                edge_q <= edge_q + E_W'(1);
                if (do_sample) rx_q <= {rx_q[W-2:0], miso};
                if (do_shift)  sr_q <= {sr_q[W-2:0], 1'b0};
                if (last_edge) done_q <= 1'b1;
            end
        end
    end

    assign sck  = cpol ^ tgl_q;
    assign mosi = sr_q[W-1];
    assign rx   = rx_q;
    assign done = done_q;
endmodule

// File: rtl/queued_spi_master.sv
module queued_spi_master
    import qspi_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 16,
    parameter int NCS    = 4,
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam int CMD_W = NCS + 2;

    // host-visible state
    logic [WORD_W-1:0] mode_q;
    logic              run_q;
    logic [IDX_W-1:0]  endq_q;
    logic              csiv_q;
    logic              done_q;
    logic [1:0]        rgn_q;
    logic [IDX_W-1:0]  hidx_q;

    // queue storage
    logic [WORD_W-1:0] tx_mem  [DEPTH];
    logic [WORD_W-1:0] rx_mem  [DEPTH];
    logic [CMD_W-1:0]  cmd_mem [DEPTH];

    // sequencer
    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [NCS-1:0]    active_q;
    logic [CMD_W-1:0]  cur_cmd;
    logic              last;
    logic [CNT_W-1:0]  ent_bits;
    logic [3:0]        bits_fld;

    // engine links
    logic              baud_en;
    logic              baud_tick;
    logic              sh_start;
    logic              sh_done;
    logic [WORD_W-1:0] sh_rx;

    logic wr_en;
    logic data_acc;

    assign wr_en    = host_sel && host_wr;
    assign data_acc = host_sel && (host_addr == REG_DATA);

    assign cur_cmd  = cmd_mem[idx_q];
    assign last     = (idx_q == endq_q);
    assign bits_fld = mode_q[MODE_BITS_L +: 4];
    assign ent_bits = cur_cmd[CMD_BITSE]
                    ? ((bits_fld == 4'd0) ? CNT_W'(WORD_W) : CNT_W'(bits_fld))
                    : CNT_W'(8);
    assign sh_start = (state_q == SQ_LOAD);
    assign baud_en  = (state_q == SQ_SHIFT) || (state_q == SQ_GAP);

    // ---------------- host register file ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= 1'b0;
            endq_q <= '0;
            csiv_q <= 1'b0;
            done_q <= 1'b0;
            rgn_q  <= RGN_TX;
            hidx_q <= '0;
        end else begin
            if (wr_en && host_addr == REG_MODE) mode_q <= host_wdata;
            if (wr_en && host_addr == REG_WRAP) begin
                endq_q <= host_wdata[IDX_W-1:0];
                csiv_q <= host_wdata[WRAP_CSIV];
            end
            if (state_q == SQ_FINISH) begin
                run_q <= 1'b0;
            end else if (wr_en && host_addr == REG_CTRL && host_wdata[CTRL_RUN]
                         && mode_q[MODE_MSTR] && state_q == SQ_IDLE) begin
                run_q <= 1'b1;
            end
            // completion beats a same-cycle clear
            if (state_q == SQ_FINISH) begin
                done_q <= 1'b1;
            end else if (wr_en && host_addr == REG_STATUS && host_wdata[0]) begin
                done_q <= 1'b0;
            end
            if (wr_en && host_addr == REG_ADDR) begin
                rgn_q  <= host_wdata[5:4];
                hidx_q <= host_wdata[IDX_W-1:0];
            end else if (data_acc) begin
                hidx_q <= hidx_q + 1'b1;
            end
        end
    end

    // ---------------- queue memories ----------------
    always_ff @(posedge clk) begin
        if (wr_en && host_addr == REG_DATA && rgn_q == RGN_TX)
            tx_mem[hidx_q] <= host_wdata;
        if (wr_en && host_addr == REG_DATA && rgn_q == RGN_CMD)
            cmd_mem[hidx_q] <= host_wdata[CMD_W-1:0];
        if (state_q == SQ_STORE)
            rx_mem[idx_q] <= sh_rx;
    end

    // ---------------- read mux ----------------
    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            REG_MODE:   host_rdata = mode_q;
            REG_CTRL:   host_rdata[CTRL_RUN] = run_q;
            REG_WRAP: begin
                host_rdata[IDX_W-1:0] = endq_q;
                host_rdata[WRAP_CSIV] = csiv_q;
            end
            REG_STATUS: host_rdata[0] = done_q;
            REG_ADDR: begin
                host_rdata[5:4]       = rgn_q;
                host_rdata[IDX_W-1:0] = hidx_q;
            end
            REG_DATA: begin
                if (rgn_q == RGN_TX)       host_rdata = tx_mem[hidx_q];
                else if (rgn_q == RGN_RX)  host_rdata = rx_mem[hidx_q];
                else if (rgn_q == RGN_CMD) host_rdata = WORD_W'(cmd_mem[hidx_q]);
            end
            default: host_rdata = '0;
        endcase
    end

    // ---------------- sequencer: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (run_q) state_d = SQ_LOAD;
            SQ_LOAD:   state_d = SQ_SHIFT;
            SQ_SHIFT:  if (sh_done) state_d = SQ_STORE;
            SQ_STORE: begin
                if (last)                    state_d = SQ_FINISH;
                else if (cur_cmd[CMD_HOLD])  state_d = SQ_LOAD;
                else                         state_d = SQ_GAP;
            end
            SQ_GAP:    if (baud_tick) state_d = SQ_LOAD;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // ---------------- sequencer: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- sequencer: outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            active_q <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE:  idx_q <= '0;
                SQ_LOAD:  active_q <= cur_cmd[NCS-1:0];
                SQ_STORE: begin
                    if (!last) idx_q <= idx_q + 1'b1;
                    if (last || !cur_cmd[CMD_HOLD]) active_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign cs_o = {NCS{csiv_q}} ^ active_q;

    qspi_baud #(.DIV_W(BAUD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (baud_en),
        .div   (mode_q[BAUD_W-1:0]),
        .tick  (baud_tick)
    );

    qspi_shifter #(.W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tick  (baud_tick),
        .cpol  (mode_q[MODE_CPOL]),
        .cpha  (mode_q[MODE_CPHA]),
        .nbits (ent_bits),
        .tx    (tx_mem[idx_q]),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .rx    (sh_rx),
        .done  (sh_done)
    );
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk
    import qspi_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_t       state,
    input logic             sck,
    input logic             cpol,
    input logic [NCS-1:0]   cs_o,
    input logic             csiv,
    input logic             run,
    input logic             done,
    input logic             mstr,
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] endq
);
    AST_SPE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_FINISH |=> !run);                                   // R3
    AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_FINISH |=> done);                                   // R3
    AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SHIFT && !$stable(sck)) |=> $stable(sck));         // R4
    AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_IDLE |-> sck == cpol);                              // R5
    AST_IDLE_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_IDLE |-> cs_o == {NCS{csiv}});                      // R7
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state != SQ_IDLE |-> idx <= endq);                              // R2
    AST_RUN_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> mstr);                                           // R10
endmodule

bind queued_spi_master qspi_master_chk #(.NCS(NCS), .IDX_W(IDX_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state_q),
    .sck   (sck),
    .cpol  (mode_q[9]),
    .cs_o  (cs_o),
    .csiv  (csiv_q),
    .run   (run_q),
    .done  (done_q),
    .mstr  (mode_q[15]),
    .idx   (idx_q),
    .endq  (endq_q)
);

// File: tb/tb_queued_spi_master.sv
module tb_queued_spi_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        sck, mosi, miso;
    logic [3:0]  cs_o;

    queued_spi_master dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit ended    = 1'b0;

    // bench view of the queue
    logic [15:0] q_tx   [16];
    logic [5:0]  q_cmd  [16];
    logic [15:0] spat   [16];
    logic [15:0] cap    [16];
    logic [3:0]  cs_seen[16];
    int          en_bits[16];
    bit          bcpol = 0, bcpha = 0, bcsiv = 0;
    int          sk = 16, sbit = 0, lead_cnt = 0, t_lead = 0, meas = 0, cs_drops = 0;
    logic [15:0] scap = 0;
    int          cyc = 0;
    bit          cs_prev = 0;
    logic        cs_act;

    assign cs_act = (cs_o != {4{bcsiv}});

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cs_prev && !cs_act) cs_drops <= cs_drops + 1;
        cs_prev <= cs_act;
    end

    // slave model: presents spat[sk] MSB first, records MOSI
    always_comb miso = (sk < 16) ? spat[sk][en_bits[sk]-1-sbit] : 1'b0;

    always @(sck) begin
        if (cs_act && sk < 16) begin
            if (sck != bcpol) begin
                lead_cnt++;
                if (lead_cnt == 1) t_lead = cyc;
                if (lead_cnt == 2) meas = cyc - t_lead;
            end
            if ((sck != bcpol) != bcpha) begin
                scap = {scap[14:0], mosi};
                cs_seen[sk] = cs_o;
                sbit++;
                if (sbit == en_bits[sk]) begin
                    cap[sk] = scap;
                    scap = 0;
                    sbit = 0;
                    sk++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 0; host_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_sel = 1; host_wr = 0; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_sel = 0;
    endtask

    function automatic logic [15:0] wmask(input int b);
        return (b >= 16) ? 16'hFFFF : 16'((32'd1 << b) - 1);
    endfunction

    function automatic int half_of(input int baud);
        return (baud < 2) ? 2 : baud;
    endfunction

    // program a queue; hold: 0 none, 1 all, 2 random
    task automatic setup_queue(input int n, input int baud, input bit cpol, input bit cpha,
                               input int fld, input bit csiv, input int hold, input int bitse);
        logic [15:0] d;
        bcpol = cpol; bcpha = cpha; bcsiv = csiv;
        for (int i = 0; i < 16; i++) begin
            bit h, b;
            h = (hold == 2) ? 1'($urandom % 2) : (hold == 1);
            b = (bitse == 2) ? 1'($urandom % 2) : (bitse == 1);
            q_cmd[i] = {h, b, 4'($urandom_range(15, 1))};
            q_tx[i]  = 16'($urandom);
            spat[i]  = 16'($urandom);
            en_bits[i] = b ? ((fld == 0) ? 16 : fld) : 8;
        end
        bus_write(3'd0, {1'b1, 1'b0, 4'(fld), cpha ? 1'b0 : 1'b0, 1'b0, 8'(baud)} |
                         (16'(cpol) << 9) | (16'(cpha) << 8));
        bus_write(3'd2, 16'((32'(csiv) << 4) | 32'(n - 1)));
        bus_write(3'd4, 16'h0020);
        for (int i = 0; i < n; i++) bus_write(3'd5, 16'(q_cmd[i]));
        bus_write(3'd4, 16'h0000);
        for (int i = 0; i < n; i++) bus_write(3'd5, q_tx[i]);
        bus_read(3'd0, d);
    endtask

    task automatic arm_slave();
        sk = 0; sbit = 0; scap = 0; lead_cnt = 0; meas = 0; cs_drops = 0;
    endtask

    task automatic start_and_wait(output int c);
        logic [15:0] d;
        arm_slave();
        bus_write(3'd1, 16'h8000);
        c = -1;
        for (int i = 1; i < 20000; i++) begin
            bus_read(3'd3, d);
            if (d[0]) begin c = i - 1; break; end
        end
    endtask

    task automatic verify_queue(input int n, input int baud);
        logic [15:0] d;
        int exp_drops;
        check(meas == 2 * half_of(baud), "R4", "sck period", meas, 2 * half_of(baud));
        bus_read(3'd1, d);
        check(d[15] == 1'b0, "R3", "run bit self-clear", d, 0);
        check(sck == bcpol, "R5", "idle sck level", sck, bcpol);
        check(cs_o == {4{bcsiv}}, "R8", "released after last", cs_o, {4{bcsiv}});
        check(sk == n, "R2", "slot count run", sk, n);
        exp_drops = 1;
        for (int i = 0; i < n - 1; i++) if (!q_cmd[i][5]) exp_drops++;
        check(cs_drops == exp_drops, "R8", "select release count", cs_drops, exp_drops);
        bus_write(3'd4, 16'h0010);
        for (int i = 0; i < n; i++) begin
            logic [15:0] m;
            m = wmask(en_bits[i]);
            bus_read(3'd5, d);
            check(d == (spat[i] & m), "R9", "rx slot", d, spat[i] & m);
            check(cap[i] == (q_tx[i] & m), "R6", "mosi word msb first", cap[i], q_tx[i] & m);
            check(cs_seen[i] == ({4{bcsiv}} ^ q_cmd[i][3:0]), "R7", "select lines",
                  cs_seen[i], {4{bcsiv}} ^ q_cmd[i][3:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int c, c2;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        bus_read(3'd3, d);
        check(d == 0, "R3", "reset status", d, 0);
        check(sck == 0 && cs_o == 4'h0, "R7", "reset pins", {sck, cs_o}, 0);
        bus_read(3'd0, d);
        check(d == 0, "R1", "reset mode", d, 0);

        // R1 address wrap and auto-advance in transmit region
        bus_write(3'd4, 16'h000F);
        bus_write(3'd5, 16'hA5A5);
        bus_write(3'd5, 16'h3C3C);
        bus_read(3'd4, d);
        check(d == 16'h0001, "R1", "index wraps in region", d, 16'h0001);
        bus_write(3'd4, 16'h000F);
        bus_read(3'd5, d);
        check(d == 16'hA5A5, "R1", "slot 15 readback", d, 16'hA5A5);
        bus_read(3'd5, d);
        check(d == 16'h3C3C, "R1", "slot 0 after wrap", d, 16'h3C3C);

        // R10 master disabled
        bus_write(3'd0, 16'h0004);
        bus_write(3'd2, 16'h0000);
        bus_write(3'd1, 16'h8000);
        bus_read(3'd1, d);
        check(d[15] == 0, "R10", "run ignored", d, 0);
        begin
            bit toggled = 0;
            logic s0 = sck;
            for (int i = 0; i < 60; i++) begin @(negedge clk); if (sck != s0) toggled = 1; end
            check(!toggled, "R10", "no sck activity", toggled, 0);
        end
        bus_read(3'd3, d);
        check(d[0] == 0, "R10", "no completion", d, 0);

        // directed modes, 8-bit slots, all held and none held
        for (int m = 0; m < 4; m++) begin
            setup_queue(4, 3, m[1], m[0], 8, m[0], m[1] ? 1 : 0, 0);
            start_and_wait(c);
            check(c >= 0, "R3", "completion seen", c, 1);
            verify_queue(4, 3);
            bus_write(3'd3, 16'h0000);
            bus_read(3'd3, d);
            check(d[0] == 1, "R3", "write 0 keeps flag", d, 1);
            bus_write(3'd3, 16'h0001);
            bus_read(3'd3, d);
            check(d[0] == 0, "R3", "write 1 clears flag", d, 0);
        end

        // R4 divider values below 2, R6 16-bit and 12-bit counts
        setup_queue(3, 0, 0, 0, 0, 1, 2, 1);
        start_and_wait(c); verify_queue(3, 0); bus_write(3'd3, 16'h0001);
        setup_queue(2, 1, 1, 1, 12, 1, 1, 2);
        start_and_wait(c); verify_queue(2, 1); bus_write(3'd3, 16'h0001);

        // random queues
        for (int r = 0; r < 8; r++) begin
            int n, baud, fld;
            n = $urandom_range(16, 1);
            baud = $urandom_range(5, 2);
            fld = ($urandom % 4 == 0) ? 0 : $urandom_range(15, 2);
            setup_queue(n, baud, 1'($urandom % 2), 1'($urandom % 2), fld,
                        1'($urandom % 2), 2, 2);
            start_and_wait(c);
            check(c >= 0, "R2", "random queue completes", c, 1);
            verify_queue(n, baud);
            bus_write(3'd3, 16'h0001);
        end

        // R3 completion and clear on the same edge
        setup_queue(2, 2, 0, 0, 8, 1, 0, 0);
        start_and_wait(c);
        bus_write(3'd3, 16'h0001);
        arm_slave();
        bus_write(3'd1, 16'h8000);
        for (int i = 0; i < c - 1; i++) bus_read(3'd0, d);
        bus_write(3'd3, 16'h0001);
        bus_read(3'd3, d);
        check(d[0] == 1, "R3", "set wins over same-cycle clear", d, 1);
        bus_read(3'd1, d);
        check(d[15] == 0, "R3", "run cleared after race", d, 0);
        c2 = c;
        check(c2 > 0, "R3", "race timing measured", c2, 1);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule